// File: doc/BRIEF.md
# Shared Instruction/Data Memory Port Arbiter

This block places one single-ported synchronous memory between two requesters of a pipelined processor: the stage that fetches instructions and the stage that performs loads and stores. In each cycle at most one of them may reach the memory. When both ask in the same cycle, the load/store side always wins. The fetch side is told to stall. It keeps its address and tries again in the following cycle, and a bubble flag tells the decode stage that no instruction arrives for the lost slot.

The memory is a word array with a one-cycle read latency. Both requesters take read data from a single registered output, and a separate valid flag for each side marks whose data it is. Stores are masked per byte. Three saturating counters record granted fetches, stalled fetches and data accesses, so the cost of port sharing can be measured directly.

Top module: `uport_arbiter`

## Requirements
- R1: In no cycle are the fetch grant (`fetchReady`) and the data grant (`dataReady`) both high. `dataReady` equals `dataValid` in every cycle.
- R2: When `fetchValid` and `dataValid` are both high, the data request is granted, `fetchReady` is low and `fetchStall` is high.
- R3: In the cycle after a stalled fetch, `fetchBubble` is high and `fetchRvalid` is low. After any other cycle, `fetchBubble` is low.
- R4: With `dataValid` low, every cycle with `fetchValid` high is granted (`fetchReady` high, `fetchStall` low).
- R5: One cycle after a fetch grant, `fetchRvalid` is high and `fetchRdata` holds the memory word at the granted `fetchAddr`. Otherwise `fetchRvalid` is low.
- R6: A granted store (`dataWrite`=1) updates the word at `dataAddr` on the granting clock edge. Bit b of `dataByteEn` enables data bits 8b+7 down to 8b. Lanes whose enable bit is clear keep their old value.
- R7: One cycle after a granted load (`dataWrite`=0), `dataRvalid` is high and `dataRdata` holds the word at `dataAddr`. Stores never raise `dataRvalid`.
- R8: `cntFetchGrant`, `cntFetchStall` and `cntDataGrant` each add one per cycle of granted fetch, stalled fetch and granted data access, respectively. Each one stops at its all-ones value.
- R9: A synchronous reset (`rst` high at a clock edge) clears all three counters, `fetchRvalid`, `dataRvalid` and `fetchBubble`. Memory contents are kept.
- R10: When fetch requests every cycle, the number of stalled fetch cycles equals the number of data accesses. The stall ratio therefore equals the fraction of cycles that carry a load or store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchValid | input | 1 | Fetch request |
| fetchAddr | input | AW | Fetch word address, held while stalled |
| fetchReady | output | 1 | Fetch granted this cycle |
| fetchStall | output | 1 | Fetch denied this cycle |
| fetchRdata | output | DW | Fetched instruction word |
| fetchRvalid | output | 1 | fetchRdata valid |
| fetchBubble | output | 1 | No instruction for decode in this cycle because of a stall |
| dataValid | input | 1 | Load/store request |
| dataWrite | input | 1 | 1 = store, 0 = load |
| dataAddr | input | AW | Data word address |
| dataWdata | input | DW | Store data |
| dataByteEn | input | DW/8 | Store byte enables |
| dataReady | output | 1 | Data access granted |
| dataRdata | output | DW | Load data |
| dataRvalid | output | 1 | dataRdata valid |
| cntFetchGrant | output | CW | Granted fetch count |
| cntFetchStall | output | CW | Stalled fetch count |
| cntDataGrant | output | CW | Granted data access count |

## Verification
The hardest situations to reach from the ports are counter saturation and the exact match between stall cycles and data traffic over a long mixed run.

The bench first fills the memory with stores and resets the counters. It then runs a random phase in which fetch requests every cycle and roughly a third of the cycles carry a load or store with random byte masks. In that phase the stall tally must equal the data tally. A long fetch-only run follows, which pushes the grant counter into saturation with a narrow counter width. Directed byte-mask stores followed by loads check lane merging.

// File: rtl/uport_pkg.sv
package uport_pkg;
  typedef struct packed {
    logic grantFetch;
    logic grantData;
    logic doWrite;
    logic doRead;
    logic stallFetch;
  } portStrobes_t;
endpackage

// File: rtl/uport_satcnt.sv
module uport_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (inc && q != TOP) q <= q + 1'b1;
  end
endmodule

// File: rtl/uport_ctrl.sv
module uport_ctrl
  import uport_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         fetchValid,
  input  logic         dataValid,
  input  logic         dataWrite,
  output portStrobes_t strb,
  output logic         fetchRvalid,
  output logic         dataRvalid,
  output logic         fetchBubble
);
  // The later stage (load/store) always outranks fetch.
  always_comb begin
    strb.grantData  = dataValid;
    strb.grantFetch = fetchValid && !dataValid;
    strb.stallFetch = fetchValid && dataValid;
    strb.doWrite    = dataValid && dataWrite;
    strb.doRead     = strb.grantFetch || (dataValid && !dataWrite);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchRvalid <= 1'b0;
      dataRvalid  <= 1'b0;
      fetchBubble <= 1'b0;
    end else begin
      fetchRvalid <= strb.grantFetch;
      dataRvalid  <= strb.grantData && !strb.doWrite;
      fetchBubble <= strb.stallFetch;
    end
  end
endmodule

// File: rtl/uport_dpath.sv
module uport_dpath
  import uport_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  portStrobes_t    strb,
  input  logic [AW-1:0]   fetchAddr,
  input  logic [AW-1:0]   dataAddr,
  input  logic [DW-1:0]   dataWdata,
  input  logic [DW/8-1:0] dataByteEn,
  output logic [DW-1:0]   portRdata,
  output logic [CW-1:0]   cntFetchGrant,
  output logic [CW-1:0]   cntFetchStall,
  output logic [CW-1:0]   cntDataGrant
);
  localparam int DEPTH = 1 << AW;
  localparam int LANES = DW / 8;

  logic [DW-1:0] memArray [DEPTH];
  logic [AW-1:0] portAddr;

  assign portAddr = strb.grantFetch ? fetchAddr : dataAddr;

  always_ff @(posedge clk) begin
    if (strb.doWrite) begin
      for (int lane = 0; lane < LANES; lane++) begin
        if (dataByteEn[lane])
          memArray[dataAddr][lane*8 +: 8] <= dataWdata[lane*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.doRead) portRdata <= memArray[portAddr];
  end

  uport_satcnt #(.W(CW)) u_cntFg (.clk(clk), .rst(rst), .inc(strb.grantFetch), .q(cntFetchGrant));
  uport_satcnt #(.W(CW)) u_cntFs (.clk(clk), .rst(rst), .inc(strb.stallFetch), .q(cntFetchStall));
  uport_satcnt #(.W(CW)) u_cntDg (.clk(clk), .rst(rst), .inc(strb.grantData),  .q(cntDataGrant));
endmodule

// File: rtl/uport_arbiter.sv
module uport_arbiter
  import uport_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetchValid,
  input  logic [AW-1:0]   fetchAddr,
  output logic            fetchReady,
  output logic            fetchStall,
  output logic [DW-1:0]   fetchRdata,
  output logic            fetchRvalid,
  output logic            fetchBubble,
  input  logic            dataValid,
  input  logic            dataWrite,
  input  logic [AW-1:0]   dataAddr,
  input  logic [DW-1:0]   dataWdata,
  input  logic [DW/8-1:0] dataByteEn,
  output logic            dataReady,
  output logic [DW-1:0]   dataRdata,
  output logic            dataRvalid,
  output logic [CW-1:0]   cntFetchGrant,
  output logic [CW-1:0]   cntFetchStall,
  output logic [CW-1:0]   cntDataGrant
);
  portStrobes_t strb;
  logic [DW-1:0] portRdata;

  uport_ctrl u_ctrl (
    .clk(clk), .rst(rst), .fetchValid(fetchValid), .dataValid(dataValid),
    .dataWrite(dataWrite), .strb(strb), .fetchRvalid(fetchRvalid),
    .dataRvalid(dataRvalid), .fetchBubble(fetchBubble)
  );

  uport_dpath #(.AW(AW), .DW(DW), .CW(CW)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .fetchAddr(fetchAddr), .dataAddr(dataAddr),
    .dataWdata(dataWdata), .dataByteEn(dataByteEn), .portRdata(portRdata),
    .cntFetchGrant(cntFetchGrant), .cntFetchStall(cntFetchStall),
    .cntDataGrant(cntDataGrant)
  );

  assign fetchReady = strb.grantFetch;
  assign fetchStall = strb.stallFetch;
  assign dataReady  = strb.grantData;
  assign fetchRdata = portRdata;
  assign dataRdata  = portRdata;
endmodule

// File: rtl/uport_arbiter_chk.sv
module uport_arbiter_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          fetchValid,
  input logic          fetchReady,
  input logic          fetchStall,
  input logic          fetchRvalid,
  input logic          fetchBubble,
  input logic          dataValid,
  input logic          dataWrite,
  input logic          dataReady,
  input logic          dataRvalid,
  input logic [CW-1:0] cntFetchGrant,
  input logic [CW-1:0] cntFetchStall,
  input logic [CW-1:0] cntDataGrant
);
  a_r1_single_owner: assert property (@(posedge clk) disable iff (rst)
    !(fetchReady && dataReady));

  a_r2_data_wins: assert property (@(posedge clk) disable iff (rst)
    (fetchValid && dataValid) |-> (dataReady && fetchStall && !fetchReady));

  a_r3_bubble_follows: assert property (@(posedge clk) disable iff (rst)
    fetchStall |=> (fetchBubble && !fetchRvalid));

  a_r4_fetch_alone: assert property (@(posedge clk) disable iff (rst)
    (fetchValid && !dataValid) |-> (fetchReady && !fetchStall));

  a_r5_fetch_return: assert property (@(posedge clk) disable iff (rst)
    fetchReady |=> fetchRvalid);

  a_r7_load_return: assert property (@(posedge clk) disable iff (rst)
    (dataReady && !dataWrite) |=> dataRvalid);

  a_r8_stall_sat: assert property (@(posedge clk) disable iff (rst)
    (cntFetchStall == '1) |=> (cntFetchStall == '1));

  a_r8_grant_sat: assert property (@(posedge clk) disable iff (rst)
    (cntFetchGrant == '1) |=> (cntFetchGrant == '1));

  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (cntFetchGrant == '0 && cntFetchStall == '0 && cntDataGrant == '0
             && !fetchBubble && !fetchRvalid && !dataRvalid));
endmodule

bind uport_arbiter uport_arbiter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .fetchValid(fetchValid), .fetchReady(fetchReady),
  .fetchStall(fetchStall), .fetchRvalid(fetchRvalid), .fetchBubble(fetchBubble),
  .dataValid(dataValid), .dataWrite(dataWrite), .dataReady(dataReady),
  .dataRvalid(dataRvalid), .cntFetchGrant(cntFetchGrant),
  .cntFetchStall(cntFetchStall), .cntDataGrant(cntDataGrant)
);

// File: tb/uport_arbiter_bench.sv
module uport_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int CW = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [CW-1:0] CMAX = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetchValid = 1'b0, dataValid = 1'b0, dataWrite = 1'b0;
  logic [AW-1:0] fetchAddr = '0, dataAddr = '0;
  logic [DW-1:0] dataWdata = '0;
  logic [DW/8-1:0] dataByteEn = '0;
  logic fetchReady, fetchStall, fetchRvalid, fetchBubble, dataReady, dataRvalid;
  logic [DW-1:0] fetchRdata, dataRdata;
  logic [CW-1:0] cntFetchGrant, cntFetchStall, cntDataGrant;

  always #(CLK_PERIOD/2) clk = ~clk;

  uport_arbiter #(.AW(AW), .DW(DW), .CW(CW)) u_uport_arbiter (
    .clk(clk), .rst(rst), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchReady(fetchReady), .fetchStall(fetchStall), .fetchRdata(fetchRdata),
    .fetchRvalid(fetchRvalid), .fetchBubble(fetchBubble), .dataValid(dataValid),
    .dataWrite(dataWrite), .dataAddr(dataAddr), .dataWdata(dataWdata),
    .dataByteEn(dataByteEn), .dataReady(dataReady), .dataRdata(dataRdata),
    .dataRvalid(dataRvalid), .cntFetchGrant(cntFetchGrant),
    .cntFetchStall(cntFetchStall), .cntDataGrant(cntDataGrant)
  );

  int checks = 0, failures = 0;
  logic [DW-1:0] model [DEPTH];
  logic expFRv = 0, expDRv = 0, expBub = 0;
  logic [DW-1:0] expFData = '0, expDData = '0;
  logic [CW-1:0] mFg = '0, mFs = '0, mDg = '0;
  int tallyStall = 0, tallyData = 0, tallyCycles = 0;
  logic [AW-1:0] pc = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [CW-1:0] satInc(input logic [CW-1:0] v, input logic en);
    return (en && v != CMAX) ? v + 1'b1 : v;
  endfunction

  function automatic logic [DW-1:0] mergeLanes(input logic [DW-1:0] old,
      input logic [DW-1:0] wd, input logic [DW/8-1:0] be);
    logic [DW-1:0] r = old;
    for (int b = 0; b < DW/8; b++) if (be[b]) r[b*8 +: 8] = wd[b*8 +: 8];
    return r;
  endfunction

  // One cycle: check registered results of the previous cycle, then drive and check grants.
  task automatic step(input logic fv, input logic [AW-1:0] fa, input logic dv,
      input logic dw, input logic [AW-1:0] da, input logic [DW-1:0] wd,
      input logic [DW/8-1:0] be);
    logic gF, st;
    @(negedge clk);
    check("R5 fetchRvalid", {31'b0, fetchRvalid}, {31'b0, expFRv});
    if (expFRv) check("R5 fetchRdata", fetchRdata, expFData);
    check("R7 dataRvalid", {31'b0, dataRvalid}, {31'b0, expDRv});
    if (expDRv) check("R6/R7 dataRdata", dataRdata, expDData);
    check("R3 fetchBubble", {31'b0, fetchBubble}, {31'b0, expBub});
    check("R8 cntFetchGrant", 32'(cntFetchGrant), 32'(mFg));
    check("R8 cntFetchStall", 32'(cntFetchStall), 32'(mFs));
    check("R8 cntDataGrant", 32'(cntDataGrant), 32'(mDg));
    fetchValid = fv; fetchAddr = fa; dataValid = dv; dataWrite = dw;
    dataAddr = da; dataWdata = wd; dataByteEn = be;
    #1;
    gF = fv && !dv;
    st = fv && dv;
    check(dv ? "R2 fetchReady" : "R4 fetchReady", {31'b0, fetchReady}, {31'b0, gF});
    check("R2 fetchStall", {31'b0, fetchStall}, {31'b0, st});
    check("R1 dataReady", {31'b0, dataReady}, {31'b0, dv});
    expFRv = gF; expFData = model[fa];
    expDRv = dv && !dw; expDData = model[da];
    expBub = st;
    mFg = satInc(mFg, gF); mFs = satInc(mFs, st); mDg = satInc(mDg, dv);
    if (dv && dw) model[da] = mergeLanes(model[da], wd, be);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; fetchValid = 0; dataValid = 0; dataWrite = 0;
    @(negedge clk);
    @(negedge clk);
    check("R9 cntFetchGrant", 32'(cntFetchGrant), 32'd0);
    check("R9 cntFetchStall", 32'(cntFetchStall), 32'd0);
    check("R9 cntDataGrant", 32'(cntDataGrant), 32'd0);
    check("R9 valids/bubble", {29'b0, fetchRvalid, dataRvalid, fetchBubble}, 32'd0);
    rst = 1'b0;
    mFg = '0; mFs = '0; mDg = '0; expFRv = 0; expDRv = 0; expBub = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    doReset();
    // Fill memory with full-word stores (R6).
    for (int a = 0; a < DEPTH; a++)
      step(0, '0, 1, 1, AW'(a), $urandom(), '1);
    // Byte-lane merge, directed (R6): expect aa22cc44.
    step(0, '0, 1, 1, AW'(5), 32'haabbccdd, 4'hf);
    step(0, '0, 1, 1, AW'(5), 32'h11223344, 4'b0101);
    step(0, '0, 1, 0, AW'(5), '0, '0);
    step(0, '0, 0, 0, '0, '0, '0);
    check("R6 lane merge model", model[5], 32'haa22cc44);
    doReset();
    // Fetch alone streams (R4), then a back-to-back collision (R2, R3).
    for (int i = 0; i < 4; i++) step(1, AW'(i), 0, 0, '0, '0, '0);
    step(1, AW'(4), 1, 0, AW'(9), '0, '0);
    step(1, AW'(4), 1, 1, AW'(9), 32'h0badf00d, 4'b1000);
    step(1, AW'(4), 0, 0, '0, '0, '0);
    step(0, '0, 0, 0, '0, '0, '0);
    doReset();
    // Random mix with fetch always requesting (R10).
    for (int i = 0; i < 200; i++) begin
      logic dv;
      logic [DW/8-1:0] be;
      dv = ($urandom_range(99) < 33);
      be = DW/8'($urandom());
      step(1, pc, dv, dv & $urandom_range(1), AW'($urandom()), $urandom(), be);
      tallyCycles++;
      if (dv) begin tallyStall++; tallyData++; end
      else pc = pc + 1'b1;
    end
    step(0, '0, 0, 0, '0, '0, '0);
    check("R10 stall count vs data count", 32'(cntFetchStall), 32'(tallyData));
    check("R10 bench stall tally", 32'(tallyStall), 32'(tallyData));
    $display("R10 stall ratio %0d/%0d cycles, data fraction %0d/%0d",
             tallyStall, tallyCycles, tallyData, tallyCycles);
    // Fetch-only run long enough to saturate the grant counter (R8).
    for (int i = 0; i < 300; i++) step(1, AW'(i), 0, 0, '0, '0, '0);
    step(0, '0, 0, 0, '0, '0, '0);
    check("R8 grant counter saturated", 32'(cntFetchGrant), 32'(CMAX));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule